// File: doc/BRIEF.md
# BCD Calendar Timekeeper with Read-Safe Update

This block keeps the time of day and the calendar date in packed BCD in a bank of eight byte registers. The order is seconds, minutes, hours with the century flags, day of week, date, month, year, and a control byte. A one-cycle pulse on `sec_tick` advances the count by one second. The carries run from seconds through the year. At the turn of the century a century bit inverts, but only when its enable flag is set.

A host writes any register through a byte-wide write port. It reads through a session port. `rd_open` loads a byte pointer, `rd_step` moves it forward by one, and `rd_close` ends the session. The seven time registers (addresses 0 to 6) form a burst that wraps from 6 to 0. The control byte at address 7 is reached only on its own and is plain storage.

While a session points into the time registers, register updates are held back so that a multi-byte read sees one consistent snapshot. The hold lasts until the session closes or until a window of `HOLD_CYC` cycles runs out. A tick that arrives during the hold is kept, and it is applied as soon as the hold ends, so no second is lost.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the eight bytes read, by address 0..7: 00, 00, 00, 01, 01, 01, 00, 00.
- R2: Each accepted tick adds one second in BCD. Seconds and minutes wrap from 59 to 00 and carry. Hours, held in bits 5:0 of address 2, count 00..23 and wrap to 00 with a day carry.
- R3: Day of week, held in bits 2:0 of address 3, counts 1..7 on each day carry and goes from 7 back to 1.
- R4: On a day carry the date, held in bits 5:0 of address 4, goes to 01 once it has reached the month's length. Month lengths are 31 days, or 30 for months 04, 06, 09 and 11, with February having 29 days when the year is divisible by 4 (year 00 included) and 28 otherwise. The month, held in bits 4:0 of address 5, then goes from 12 to 01 with a year increment, or otherwise adds one. The year at address 6 goes from 99 to 00.
- R5: Bit 7 of address 2 is the century enable and bit 6 is the century bit. When the year rolls from 99 to 00, the century bit inverts if the enable is 1 and holds its value if the enable is 0.
- R6: While bit 7 of address 0 is 1, ticks are ignored and all registers hold. Once it is cleared, counting resumes from the stored value.
- R7: A write loads the register the cycle after it is presented. The stored widths are: address 0 all 8 bits, address 1 bits 6:0, address 2 all 8 bits, address 3 bits 2:0, address 4 bits 5:0, address 5 bits 4:0, addresses 6 and 7 all 8 bits. Unstored bits read as 0.
- R8: `rd_data` shows the register at the session pointer. `rd_open` loads the pointer from `rd_addr`. `rd_step` moves the pointer from 6 to 0, leaves it at 7 when it is at 7, and otherwise adds one. Each of these takes effect one cycle after it is presented.
- R9: While a session is open with the pointer at 0..6, no tick changes any register. This hold lasts for at most `HOLD_CYC` cycles counted from the `rd_open` cycle.
- R10: Ticks that arrive during the hold are merged into a single pending second. That second is applied in the first cycle after the hold ends, whether the hold ends because the session closed or because the window ran out.
- R11: A write to addresses 0..6 discards any pending second. A write to address 7 does not discard it.
- R12: The control byte at address 7 is plain storage. A session whose pointer is at 7 does not hold ticks back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse, one per second |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_open | input | 1 | Open a read session at `rd_addr` |
| rd_addr | input | 3 | Start address of a read session |
| rd_step | input | 1 | Advance the read pointer |
| rd_close | input | 1 | End the read session |
| rd_data | output | 8 | Byte at the read pointer |

## Verification
Ticks and writes change registers at the clock edge that samples them. Opens and steps move the pointer at that same edge. The bench therefore drives each input on a falling edge and samples `rd_data` at the next falling edge. A tick deferred by an open session must still read as the old value when the bench samples just after the last edge of the window, or just after the close edge. It must read as advanced by exactly one second at the sample after that. The bench counts those edges explicitly with a window of 6 cycles. The calendar is swept over every month of all 100 years, over every hour and every day of week, and through a continuous run of 3720 seconds. Each expected value is computed arithmetically.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NUM_REGS = 8;

    typedef enum logic [2:0] {
        RA_SEC  = 3'd0,
        RA_MIN  = 3'd1,
        RA_HOUR = 3'd2,
        RA_DOW  = 3'd3,
        RA_DATE = 3'd4,
        RA_MON  = 3'd5,
        RA_YEAR = 3'd6,
        RA_CTRL = 3'd7
    } rtc_addr_e;

    typedef struct packed {
        logic       halt;
        logic [6:0] sec;
        logic [6:0] min;
        logic       cen_en;
        logic       cen;
        logic [5:0] hour;
        logic [2:0] dow;
        logic [5:0] date;
        logic [4:0] mon;
        logic [7:0] year;
        logic [7:0] ctrl;
    } rtc_regs_t;

    localparam rtc_regs_t RTC_RESET = '{
        halt: 1'b0, sec: 7'h00, min: 7'h00, cen_en: 1'b0, cen: 1'b0,
        hour: 6'h00, dow: 3'd1, date: 6'h01, mon: 5'h01, year: 8'h00,
        ctrl: 8'h00
    };

    // Add one to a two-digit packed BCD value.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // A BCD year is a multiple of 4 when an even tens digit pairs with
    // ones 0/4/8, or an odd tens digit pairs with ones 2/6.
    function automatic logic year_is_leap(input logic [7:0] y);
        if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    function automatic logic [5:0] month_last(input logic [4:0] m,
                                              input logic [7:0] y);
        case (m)
            5'h02:                      return year_is_leap(y) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

    function automatic logic [7:0] reg_byte(input rtc_regs_t r,
                                            input logic [2:0] a);
        case (rtc_addr_e'(a))
            RA_SEC:  return {r.halt, r.sec};
            RA_MIN:  return {1'b0, r.min};
            RA_HOUR: return {r.cen_en, r.cen, r.hour};
            RA_DOW:  return {5'd0, r.dow};
            RA_DATE: return {2'd0, r.date};
            RA_MON:  return {3'd0, r.mon};
            RA_YEAR: return r.year;
            default: return r.ctrl;
        endcase
    endfunction

endpackage

// File: rtl/rtc_read_gate.sv
module rtc_read_gate
    import rtc_pkg::*;
#(
    parameter int HOLD_CYC = 25,
    localparam int CW = $clog2(HOLD_CYC + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_open,
    input  logic [2:0] rd_addr,
    input  logic       rd_step,
    input  logic       rd_close,
    input  logic       sec_tick,
    input  logic       halted,
    input  logic       time_wr,
    output logic [2:0] rd_ptr,
    output logic       advance
);

    logic          sess;
    logic          pend;
    logic [CW-1:0] win_cnt;
    logic          hold;
    logic          live_tick;

    assign hold      = sess && (rd_ptr != 3'(RA_CTRL)) && (win_cnt < CW'(HOLD_CYC));
    assign live_tick = sec_tick && !halted;
    assign advance   = !hold && !halted && !time_wr && (live_tick || pend);

    always_ff @(posedge clk) begin
        if (rst) begin
            sess    <= 1'b0;
            rd_ptr  <= 3'd0;
            win_cnt <= '0;
        end else if (rd_open) begin
            sess    <= 1'b1;
            rd_ptr  <= rd_addr;
            win_cnt <= '0;
        end else begin
            if (rd_close) sess <= 1'b0;
            if (hold) win_cnt <= win_cnt + CW'(1);
            if (rd_step) begin
                if (rd_ptr == 3'(RA_YEAR))      rd_ptr <= 3'(RA_SEC);
                else if (rd_ptr != 3'(RA_CTRL)) rd_ptr <= rd_ptr + 3'd1;
            end
        end
    end

    // One pending second at most; a tick arriving as the pending one is
    // applied stays pending for the next cycle.
    always_ff @(posedge clk) begin
        if (rst || time_wr) pend <= 1'b0;
        else if (hold)      pend <= pend || live_tick;
        else if (!halted)   pend <= pend && live_tick;
    end

    assert_hold_defers_R9: assert property (@(posedge clk) disable iff (rst)
        (hold && live_tick && !time_wr) |=> pend);

    assert_window_bound_R9: assert property (@(posedge clk) disable iff (rst)
        win_cnt <= CW'(HOLD_CYC));

    assert_release_R10: assert property (@(posedge clk) disable iff (rst)
        (pend && !hold && !halted && !time_wr && !live_tick) |=> !pend);

    assert_write_clears_R11: assert property (@(posedge clk) disable iff (rst)
        time_wr |=> !pend);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       advance,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    output rtc_regs_t  regs
);

    rtc_regs_t nx;
    logic c_min, c_hour, c_day, c_mon, c_year, c_cen;

    always_comb begin
        nx     = regs;
        c_min  = regs.sec == 7'h59;
        c_hour = c_min && (regs.min == 7'h59);
        c_day  = c_hour && (regs.hour == 6'h23);
        c_mon  = c_day && (regs.date == month_last(regs.mon, regs.year));
        c_year = c_mon && (regs.mon == 5'h12);
        c_cen  = c_year && (regs.year == 8'h99);

        nx.sec = c_min ? 7'h00 : 7'(bcd_inc({1'b0, regs.sec}));
        if (c_min)  nx.min  = c_hour ? 7'h00 : 7'(bcd_inc({1'b0, regs.min}));
        if (c_hour) nx.hour = c_day ? 6'h00 : 6'(bcd_inc({2'b0, regs.hour}));
        if (c_day) begin
            nx.dow  = (regs.dow == 3'd7) ? 3'd1 : regs.dow + 3'd1;
            nx.date = c_mon ? 6'h01 : 6'(bcd_inc({2'b0, regs.date}));
        end
        if (c_mon)  nx.mon  = c_year ? 5'h01 : 5'(bcd_inc({3'b0, regs.mon}));
        if (c_year) nx.year = c_cen ? 8'h00 : bcd_inc(regs.year);
        if (c_cen && regs.cen_en) nx.cen = !regs.cen;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= RTC_RESET;
        end else begin
            if (advance) regs <= nx;
            if (wr_en) begin
                case (rtc_addr_e'(wr_addr))
                    RA_SEC:  {regs.halt, regs.sec} <= wr_data;
                    RA_MIN:  regs.min <= wr_data[6:0];
                    RA_HOUR: {regs.cen_en, regs.cen, regs.hour} <= wr_data;
                    RA_DOW:  regs.dow <= wr_data[2:0];
                    RA_DATE: regs.date <= wr_data[5:0];
                    RA_MON:  regs.mon <= wr_data[4:0];
                    RA_YEAR: regs.year <= wr_data;
                    default: regs.ctrl <= wr_data;
                endcase
            end
        end
    end

    assert_sec_moves_R2: assert property (@(posedge clk) disable iff (rst)
        (advance && !wr_en) |=> (regs.sec != $past(regs.sec)));

    assert_century_only_at_rollover_R5: assert property (@(posedge clk) disable iff (rst)
        (!(wr_en && wr_addr == 3'(RA_HOUR)) && !(advance && regs.year == 8'h99))
        |=> $stable(regs.cen));

endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
    import rtc_pkg::*;
#(
    parameter int HOLD_CYC = 25
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_tick,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_open,
    input  logic [2:0] rd_addr,
    input  logic       rd_step,
    input  logic       rd_close,
    output logic [7:0] rd_data
);

    rtc_regs_t  regs;
    logic [2:0] rd_ptr;
    logic       advance;
    logic       time_wr;

    assign time_wr = wr_en && (wr_addr != 3'(RA_CTRL));

    rtc_read_gate #(.HOLD_CYC(HOLD_CYC)) u_gate (
        .clk      (clk),
        .rst      (rst),
        .rd_open  (rd_open),
        .rd_addr  (rd_addr),
        .rd_step  (rd_step),
        .rd_close (rd_close),
        .sec_tick (sec_tick),
        .halted   (regs.halt),
        .time_wr  (time_wr),
        .rd_ptr   (rd_ptr),
        .advance  (advance)
    );

    rtc_calendar u_cal (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .regs    (regs)
    );

    assign rd_data = reg_byte(regs, rd_ptr);

    assert_halt_freezes_R6: assert property (@(posedge clk) disable iff (rst)
        (regs.halt && !wr_en) |=> $stable(regs));

endmodule

// File: tb/sim_bcd_rtc.sv
module sim_bcd_rtc;

    localparam int HW = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic       rd_open = 1'b0;
    logic [2:0] rd_addr = 3'd0;
    logic       rd_step = 1'b0;
    logic       rd_close = 1'b0;
    logic [7:0] rd_data;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] rb [0:7];

    bcd_rtc #(.HOLD_CYC(HW)) u0 (
        .clk(clk), .rst(rst), .sec_tick(sec_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_open(rd_open), .rd_addr(rd_addr), .rd_step(rd_step),
        .rd_close(rd_close), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int mlen(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic burst(input logic [2:0] a, input int n);
        @(negedge clk); rd_open = 1'b1; rd_addr = a;
        @(negedge clk); rd_open = 1'b0;
        for (int i = 0; i < n; i++) begin
            rb[i] = rd_data;
            if (i < n - 1) begin
                rd_step = 1'b1;
                @(negedge clk); rd_step = 1'b0;
            end
        end
        rd_close = 1'b1;
        @(negedge clk); rd_close = 1'b0;
    endtask

    task automatic set_time(input int h, input int m, input int s);
        wr(3'd2, bcd(h)); wr(3'd1, bcd(m)); wr(3'd0, bcd(s));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        burst(3'd0, 7);
        chk("R1 sec", rb[0], 8'h00); chk("R1 min", rb[1], 8'h00);
        chk("R1 hour", rb[2], 8'h00); chk("R1 dow", rb[3], 8'h01);
        chk("R1 date", rb[4], 8'h01); chk("R1 mon", rb[5], 8'h01);
        chk("R1 year", rb[6], 8'h00);
        burst(3'd7, 1); chk("R1 ctrl", rb[0], 8'h00);

        // R8 pointer wrap 6->0 and hold at 7
        wr(3'd0, 8'h33);
        burst(3'd6, 2); chk("R8 wrap", rb[1], 8'h33);
        wr(3'd7, 8'hA5);
        burst(3'd7, 3); chk("R8 stay7", rb[2], 8'hA5);

        // R7 field masks
        wr(3'd1, 8'hFF); wr(3'd3, 8'hFF); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
        burst(3'd1, 5);
        chk("R7 min", rb[0], 8'h7F); chk("R7 dow", rb[2], 8'h07);
        chk("R7 date", rb[3], 8'h3F); chk("R7 mon", rb[4], 8'h1F);

        // R2 continuous run across midnight
        begin
            int t;
            t = 22 * 3600 + 58 * 60;
            set_time(22, 58, 0);
            for (int k = 0; k < 3720; k++) begin
                tick();
                t = (t + 1) % 86400;
                burst(3'd0, 3);
                chk("R2 sec", rb[0], bcd(t % 60));
                chk("R2 min", rb[1], bcd((t / 60) % 60));
                chk("R2 hour", rb[2], bcd(t / 3600));
            end
        end

        // R2 every hour rollover
        for (int h = 0; h < 24; h++) begin
            set_time(h, 59, 59);
            tick();
            burst(3'd0, 3);
            chk("R2 hr sec", rb[0], 8'h00); chk("R2 hr min", rb[1], 8'h00);
            chk("R2 hr", rb[2], bcd((h + 1) % 24));
        end

        // R3 day of week
        for (int d = 1; d <= 7; d++) begin
            wr(3'd3, 8'(d));
            set_time(23, 59, 59);
            tick();
            burst(3'd3, 1);
            chk("R3 dow", rb[0], 8'((d == 7) ? 1 : d + 1));
        end

        // R4 month ends for every month of every year
        for (int y = 0; y < 100; y++) begin
            for (int m = 1; m <= 12; m++) begin
                wr(3'd6, bcd(y)); wr(3'd5, bcd(m)); wr(3'd4, bcd(mlen(m, y)));
                set_time(23, 59, 59);
                tick();
                burst(3'd4, 3);
                chk("R4 date", rb[0], 8'h01);
                chk("R4 mon", rb[1], bcd(m % 12 + 1));
                chk("R4 year", rb[2], bcd((m == 12) ? (y + 1) % 100 : y));
            end
        end

        // R5 century toggles only with enable
        wr(3'd6, 8'h99); wr(3'd5, 8'h12); wr(3'd4, 8'h31);
        wr(3'd2, 8'hA3); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        tick(); burst(3'd2, 1); chk("R5 enabled", rb[0], 8'hC0);
        wr(3'd6, 8'h99); wr(3'd5, 8'h12); wr(3'd4, 8'h31);
        wr(3'd2, 8'h63); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        tick(); burst(3'd2, 1); chk("R5 disabled", rb[0], 8'h40);

        // R6 stop flag
        wr(3'd0, 8'h95);
        tick(); tick(); tick();
        burst(3'd0, 1); chk("R6 frozen", rb[0], 8'h95);
        wr(3'd0, 8'h15);
        tick(); burst(3'd0, 1); chk("R6 resumed", rb[0], 8'h16);

        // R9/R10 hold until window end, two ticks merge into one
        wr(3'd0, 8'h10);
        @(negedge clk); rd_open = 1'b1; rd_addr = 3'd0;
        @(negedge clk); rd_open = 1'b0; sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        repeat (HW - 2) @(negedge clk);
        chk("R9 held in window", rd_data, 8'h10);
        @(negedge clk);
        chk("R10 applied after window", rd_data, 8'h11);
        @(negedge clk);
        chk("R10 one second only", rd_data, 8'h11);
        rd_close = 1'b1;
        @(negedge clk); rd_close = 1'b0;

        // R10 release on close
        wr(3'd0, 8'h10);
        @(negedge clk); rd_open = 1'b1; rd_addr = 3'd0;
        @(negedge clk); rd_open = 1'b0; sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0; rd_close = 1'b1;
        chk("R9 held", rd_data, 8'h10);
        @(negedge clk); rd_close = 1'b0;
        chk("R10 held at close", rd_data, 8'h10);
        @(negedge clk);
        chk("R10 applied after close", rd_data, 8'h11);

        // R11 time write discards pending
        wr(3'd0, 8'h10);
        @(negedge clk); rd_open = 1'b1; rd_addr = 3'd0;
        @(negedge clk); rd_open = 1'b0; sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h20;
        @(negedge clk); wr_en = 1'b0; rd_close = 1'b1;
        @(negedge clk); rd_close = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 time write clears", rd_data, 8'h20);

        // R11 control write keeps pending
        @(negedge clk); rd_open = 1'b1; rd_addr = 3'd0;
        @(negedge clk); rd_open = 1'b0; sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0; wr_en = 1'b1; wr_addr = 3'd7; wr_data = 8'h5A;
        @(negedge clk); wr_en = 1'b0; rd_close = 1'b1;
        @(negedge clk); rd_close = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 ctrl write keeps", rd_data, 8'h21);
        burst(3'd7, 1); chk("R12 ctrl stored", rb[0], 8'h5A);

        // R12 control session does not hold
        @(negedge clk); rd_open = 1'b1; rd_addr = 3'd7;
        @(negedge clk); rd_open = 1'b0; sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0; rd_close = 1'b1;
        @(negedge clk); rd_close = 1'b0;
        burst(3'd0, 1); chk("R12 no hold", rb[0], 8'h22);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule